// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Compare

This block is the purely combinational arithmetic-logic unit of a small load/store integer core. It takes two operand words, a shift distance and a 4-bit operation select. In the same evaluation it returns one result word and a flag that shows whether that word is zero. The core's branch logic uses the flag for equality tests. The select codes below belong to this unit. Whatever decodes instructions maps its own fields onto them.

A single adder serves addition, subtraction and both less-than comparisons. For subtraction the adder is fed the complement of B and a carry-in of one. The signed comparison takes the sign of the difference corrected by the overflow bit. The unsigned comparison uses the adder's carry-out. One barrel shifter handles all three shift forms. It shifts operand A by the distance field. A left shift is done by reversing the bits around a right shift.

Top module: `int_alu`

## Requirements
- R1: Select code 0 (add) returns A + B modulo 2^32, with no trap and no other output.
- R2: Select code 1 (subtract) returns A - B modulo 2^32, so 0x80000000 - 1 gives 0x7FFFFFFF with no trap.
- R3: Select codes 2, 3 and 4 return the bitwise AND, OR and XOR of A and B.
- R4: Select code 5 returns the complement of (A OR B), and with B = 0 it returns the complement of A.
- R5: Select code 6 returns 1 when A < B as two's-complement numbers and 0 otherwise, with bits 31..1 always 0. The answer stays correct when A - B overflows: A = 0x80000000, B = 1 gives 1, and A = 0xFFFFFFFF, B = 1 gives 1.
- R6: Select code 7 returns 1 when A < B as unsigned numbers and 0 otherwise, with bits 31..1 always 0. A = 0xFFFFFFFF, B = 1 gives 0.
- R7: Select code 8 shifts A left by the 5-bit distance (0 to 31) and fills the vacated low bits with 0.
- R8: Select code 9 shifts A right by the distance and fills the vacated high bits with 0.
- R9: Select code 10 shifts A right by the distance and fills the vacated high bits with copies of A's bit 31.
- R10: The zero output is 1 exactly when all 32 result bits are 0, for every select code.
- R11: Select codes 11 to 15 are unassigned. They return a result of 0, and so the zero output is 1.
- R12: A shift distance of 0 returns A unchanged for all three shift codes (8, 9, 10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | Operand A; also the word that is shifted |
| opb_i | input | 32 | Operand B |
| shamt_i | input | 5 | Shift distance, 0 to 31 |
| op_sel_i | input | 4 | Operation select code (see requirements) |
| result_o | output | 32 | Result word |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
Two functions share a cycle when the zero flag is computed from a comparison or subtraction whose adder overflows. Examples are subtract or signed compare with operands of opposite sign and large magnitude. There the flag has to follow a result that was just corrected for overflow. Directed pairs provoke these cases: 0x80000000 against 1, 0x7FFFFFFF against 0xFFFFFFFF, and equal operands. Constrained-random sweeps then lean on sign-boundary values. Every cycle the bench evaluates an independent behavioural model written with native signed and unsigned arithmetic. It then judges the result word and the flag together against that model.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_NOR  = 4'd5,
        OP_SLT  = 4'd6,
        OP_SLTU = 4'd7,
        OP_SLL  = 4'd8,
        OP_SRL  = 4'd9,
        OP_SRA  = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_OR  = 2'd1,
        BW_XOR = 2'd2,
        BW_NOR = 2'd3
    } bw_kind_e;

    typedef struct packed {
        logic left;
        logic arith;
    } shift_ctl_t;

    typedef struct packed {
        logic lt_signed;
        logic lt_unsigned;
    } cmp_flags_t;

    function automatic logic needs_subtract(input alu_op_e op);
        return (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
    endfunction

    function automatic bw_kind_e bw_kind_of(input alu_op_e op);
        case (op)
            OP_AND:  return BW_AND;
            OP_OR:   return BW_OR;
            OP_XOR:  return BW_XOR;
            default: return BW_NOR;
        endcase
    endfunction

    function automatic shift_ctl_t shift_ctl_of(input alu_op_e op);
        shift_ctl_t c;
        c.left  = (op == OP_SLL);
        c.arith = (op == OP_SRA);
        return c;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    always_comb begin
        b_eff   = sub_i ? ~b_i : b_i;
        full    = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_i};
        sum_o   = full[WIDTH-1:0];
        carry_o = full[WIDTH];
        ovf_o   = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
    end

    // R2: equal operands subtract to zero and borrow nothing (carry set)
    always_comb begin
        if (sub_i && (a_i == b_i)) begin
            assert_sub_equal_R2: assert (sum_o == '0 && carry_o && !ovf_o)
                else $error("equal-operand subtract not zero");
        end
    end

    // R1: adding zero never overflows and returns A
    always_comb begin
        if (!sub_i && (b_i == '0)) begin
            assert_add_identity_R1: assert (sum_o == a_i && !ovf_o && !carry_o)
                else $error("add of zero altered operand");
        end
    end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  bw_kind_e         kind_i,
    output logic [WIDTH-1:0] y_o
);
    always_comb begin
        unique case (kind_i)
            BW_AND:  y_o = a_i & b_i;
            BW_OR:   y_o = a_i | b_i;
            BW_XOR:  y_o = a_i ^ b_i;
            default: y_o = ~(a_i | b_i);
        endcase
    end

    // R4: NOR against a zero operand acts as an inverter
    always_comb begin
        if (kind_i == BW_NOR && b_i == '0) begin
            assert_nor_invert_R4: assert (y_o == ~a_i)
                else $error("NOR with zero is not NOT");
        end
    end

    // R3: XOR of a word with itself is zero, AND of a word with itself is itself
    always_comb begin
        if (a_i == b_i) begin
            assert_self_ops_R3: assert ((kind_i != BW_XOR || y_o == '0) &&
                                        (kind_i != BW_AND || y_o == a_i))
                else $error("self bitwise identity broken");
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SHW-1:0]   dist_i,
    input  shift_ctl_t       ctl_i,
    output logic [WIDTH-1:0] y_o
);
    localparam int unsigned MSB = WIDTH - 1;

    logic [WIDTH-1:0] a_rev;
    logic [WIDTH-1:0] stage [SHW+1];
    logic [WIDTH-1:0] tail_rev;
    logic             fill;

    // bit reversal used on the way in and out of a left shift
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
        assign a_rev[i]    = a_i[MSB-i];
        assign tail_rev[i] = stage[SHW][MSB-i];
    end

    assign fill     = ctl_i.arith & a_i[MSB];
    assign stage[0] = ctl_i.left ? a_rev : a_i;

    // logarithmic right shifter: stage k moves by 2^k when its distance bit is set
    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int unsigned STEP = 1 << k;
        assign stage[k+1] = dist_i[k]
            ? {{STEP{fill}}, stage[k][WIDTH-1:STEP]}
            : stage[k];
    end

    assign y_o = ctl_i.left ? tail_rev : stage[SHW];

    // R12: zero distance leaves the operand untouched
    always_comb begin
        if (dist_i == '0) begin
            assert_zero_dist_R12: assert (y_o == a_i)
                else $error("zero-distance shift changed data");
        end
    end

    // R9: arithmetic right shift keeps the sign bit
    always_comb begin
        if (ctl_i.arith && !ctl_i.left) begin
            assert_sra_sign_R9: assert (y_o[MSB] == a_i[MSB])
                else $error("arithmetic shift lost sign");
        end
    end

    // R7: a nonzero left shift always clears bit 0
    always_comb begin
        if (ctl_i.left && dist_i != '0) begin
            assert_sll_fill_R7: assert (y_o[0] == 1'b0)
                else $error("left shift did not fill with zero");
        end
    end

    // R8: a nonzero logical right shift always clears the top bit
    always_comb begin
        if (!ctl_i.left && !ctl_i.arith && dist_i != '0) begin
            assert_srl_fill_R8: assert (y_o[MSB] == 1'b0)
                else $error("logical right shift did not fill with zero");
        end
    end
endmodule

// File: rtl/int_alu.sv
module int_alu
    import alu_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    localparam int unsigned SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [SHW-1:0]   shamt_i,
    input  logic [OP_W-1:0]  op_sel_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);
    localparam int unsigned MSB = WIDTH - 1;

    alu_op_e          op;
    logic [WIDTH-1:0] sum;
    logic             carry;
    logic             ovf;
    cmp_flags_t       cmp;
    logic [WIDTH-1:0] bw_y;
    logic [WIDTH-1:0] sh_y;

    assign op = alu_op_e'(op_sel_i);

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i     (opa_i),
        .b_i     (opb_i),
        .sub_i   (needs_subtract(op)),
        .sum_o   (sum),
        .carry_o (carry),
        .ovf_o   (ovf)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .kind_i (bw_kind_of(op)),
        .y_o    (bw_y)
    );

    alu_shifter #(.WIDTH(WIDTH)) u_shifter (
        .a_i    (opa_i),
        .dist_i (shamt_i),
        .ctl_i  (shift_ctl_of(op)),
        .y_o    (sh_y)
    );

    // signed order from the overflow-corrected sign, unsigned from the borrow
    always_comb begin
        cmp.lt_signed   = sum[MSB] ^ ovf;
        cmp.lt_unsigned = ~carry;
    end

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:                  result_o = sum;
            OP_AND, OP_OR, OP_XOR, OP_NOR:   result_o = bw_y;
            OP_SLT:                          result_o = {{(WIDTH-1){1'b0}}, cmp.lt_signed};
            OP_SLTU:                         result_o = {{(WIDTH-1){1'b0}}, cmp.lt_unsigned};
            OP_SLL, OP_SRL, OP_SRA:          result_o = sh_y;
            default:                         result_o = '0;
        endcase
        zero_o = ~|result_o;
    end

    // R5: with opposite signs the negative operand is the smaller one
    always_comb begin
        if (op == OP_SLT && opa_i[MSB] != opb_i[MSB]) begin
            assert_slt_signs_R5: assert (result_o == {{(WIDTH-1){1'b0}}, opa_i[MSB]})
                else $error("signed compare wrong across signs");
        end
    end

    // R6: with differing top bits the operand with bit 31 clear is smaller
    always_comb begin
        if (op == OP_SLTU && opa_i[MSB] != opb_i[MSB]) begin
            assert_sltu_msb_R6: assert (result_o == {{(WIDTH-1){1'b0}}, opb_i[MSB]})
                else $error("unsigned compare wrong across top bit");
        end
    end

    // R10: equal operands under subtract raise the zero flag
    always_comb begin
        if (op == OP_SUB && opa_i == opb_i) begin
            assert_eq_zero_R10: assert (zero_o)
                else $error("zero flag missing on equal subtract");
        end
    end

    // R11: unassigned select codes yield zero
    always_comb begin
        if (op_sel_i > OP_SRA) begin
            assert_unassigned_R11: assert (zero_o && result_o == '0)
                else $error("unassigned code produced data");
        end
    end
endmodule

// File: tb/int_alu_tb.sv
module int_alu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  shamt = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic        zero;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    int_alu u_dut (
        .opa_i    (opa),
        .opb_i    (opb),
        .shamt_i  (shamt),
        .op_sel_i (op_sel),
        .result_o (result),
        .zero_o   (zero)
    );

    function automatic logic [31:0] ref_model(input logic [3:0] c, input logic [31:0] a,
                                              input logic [31:0] b, input logic [4:0] s);
        longint sa, sb;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (c)
            4'd0:  return a + b;
            4'd1:  return a - b;
            4'd2:  return a & b;
            4'd3:  return a | b;
            4'd4:  return a ^ b;
            4'd5:  return ~(a | b);
            4'd6:  return (sa < sb) ? 32'd1 : 32'd0;
            4'd7:  return ({32'd0, a} < {32'd0, b}) ? 32'd1 : 32'd0;
            4'd8:  return a << s;
            4'd9:  return a >> s;
            4'd10: return $unsigned($signed(a) >>> s);
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c, input logic [4:0] s);
        if (c >= 4'd8 && c <= 4'd10 && s == 5'd0) return "R12";
        case (c)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            4'd10: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic [3:0] c, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] s);
        logic [31:0] exp_r;
        logic        exp_z;
        @(posedge clk);
        op_sel = c; opa = a; opb = b; shamt = s;
        @(negedge clk);
        exp_r = ref_model(c, a, b, s);
        exp_z = (exp_r == 32'd0);
        n_cmp++;
        if (result !== exp_r || zero !== exp_z) begin
            n_bad++;
            $display("FAIL %s/R10 op=%0d a=%h b=%h s=%0d: got %h z=%b, expected %h z=%b",
                     req_of(c, s), c, a, b, s, result, zero, exp_r, exp_z);
        end
    endtask

    function automatic logic [31:0] pick_word();
        case ($urandom_range(0, 5))
            0: return 32'h8000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'hFFFF_FFFF;
            3: return 32'd1;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset state: all-zero inputs, add of zeros -> zero flag (R1, R10)
        apply(4'd0, 32'd0, 32'd0, 5'd0);
        // R1 wrap
        apply(4'd0, 32'hFFFF_FFFF, 32'd1, 5'd0);
        // R2 wrap without trap, and equal operands (R10)
        apply(4'd1, 32'h8000_0000, 32'd1, 5'd0);
        apply(4'd1, 32'h1234_5678, 32'h1234_5678, 5'd0);
        // R3 masks
        apply(4'd2, 32'h0000_0DC0, 32'h0000_3C00, 5'd0);
        apply(4'd3, 32'h0000_0DC0, 32'h0000_3C00, 5'd0);
        apply(4'd4, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 5'd0);
        // R4 NOR as NOT
        apply(4'd5, 32'h0000_3C00, 32'd0, 5'd0);
        // R5 signed compare incl. overflow cases
        apply(4'd6, 32'hFFFF_FFFF, 32'd1, 5'd0);
        apply(4'd6, 32'h8000_0000, 32'd1, 5'd0);
        apply(4'd6, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 5'd0);
        apply(4'd6, 32'd5, 32'd5, 5'd0);
        // R6 unsigned compare
        apply(4'd7, 32'hFFFF_FFFF, 32'd1, 5'd0);
        apply(4'd7, 32'd1, 32'hFFFF_FFFF, 5'd0);
        // R7..R9 shifts, extremes
        apply(4'd8, 32'hFFFF_FFFF, 32'd0, 5'd31);
        apply(4'd9, 32'hFFFF_FFFF, 32'd0, 5'd31);
        apply(4'd10, 32'h8000_0000, 32'd0, 5'd31);
        apply(4'd10, 32'h4000_0000, 32'd0, 5'd4);
        // R12 zero distance
        apply(4'd8, 32'hDEAD_BEEF, 32'd0, 5'd0);
        apply(4'd10, 32'hDEAD_BEEF, 32'd0, 5'd0);
        // R11 unassigned codes
        for (int c = 11; c < 16; c++) apply(4'(c), 32'hFFFF_FFFF, 32'h1234_5678, 5'd3);
        // constrained random sweep over all codes
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] ra, rb;
            ra = pick_word();
            rb = ($urandom_range(0, 7) == 0) ? ra : pick_word();
            apply(4'($urandom_range(0, 15)), ra, rb, 5'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule